// File: doc/BRIEF.md
# Windowed Sign-Magnitude Accumulator

This block takes one sign-magnitude sample on every clock edge and folds it into a wide two's-complement running sum. Each sample is converted on the way into the adder: the magnitude bits are inverted when the sample is negative, and the sign bit enters as the carry-in. A negative sample therefore subtracts exactly its magnitude, and negative zero adds nothing.

Samples are grouped into fixed windows of 64 consecutive cycles. The edge that takes in the last sample of a window also loads the total into a registered result output and clears the running sum. The next sample then starts a fresh window. A one-cycle pulse marks each new result, and the result holds its value until the next window closes.

A small sequencer with two named states controls the windows. **ST_FILL** covers window positions 0 to 62. **ST_LAST** covers position 63. The transition *fill_to_last* happens when the position counter reaches 62. The transition *last_to_fill* always happens one cycle after entering ST_LAST, and the counter wraps to 0 at the same time. Synchronous reset returns the sequencer to ST_FILL at position 0.

Top module: `sm_window_accum`

## Requirements
- R1: A sample is 16 bits. Bit 15 is the sign (1 = negative) and bits 14:0 are the magnitude. A positive sample adds its magnitude to the window sum and a negative sample subtracts it.
- R2: The negative-zero sample 0x8000 leaves the running sum unchanged.
- R3: The first window starts with the sample taken at the first clock edge after reset is released. The edge that takes a window's 64th sample also loads the sum of those 64 samples into `sum_o`, so the new value is visible right after that edge.
- R4: `sum_o` keeps its value in every cycle where `sum_valid_o` is low.
- R5: `sum_valid_o` is high for exactly one cycle per window: the cycle in which the new `sum_o` value first appears. It is therefore high every 64 cycles and never two cycles in a row.
- R6: The last sample of a window counts in that window only. The next window starts from zero and counts its own first sample.
- R7: All arithmetic wraps modulo 2^21, with no saturation. For example, 64 samples of 0x7FFF give 0x1FFFC0, and 64 samples of 0xFFFF give 0x000040.
- R8: While the synchronous reset `rst_i` is high, `sum_o` and `sum_valid_o` go to 0, the running sum goes to 0, and the window position restarts. The sample presented during a reset cycle is not counted.
- R9: The samples 0x0000, 0x8001, 0x0001, 0x0000 cancel to zero. A window made of them followed by zeros publishes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_i | input | 16 | Sign-magnitude sample, one per cycle |
| sum_o | output | 21 | Registered two's-complement total of the last completed window |
| sum_valid_o | output | 1 | One-cycle pulse marking a new `sum_o` value |

## Verification
The bench targets the window edge. A design that drops the 64th sample, adds it to the next window, or publishes one cycle early or late would give a wrong total and a misplaced pulse. Negative zero and ±1 cancellation are driven directly, since a converter that only inverts the magnitude without a carry-in would drift by one per negative sample. Full-scale windows of 0x7FFF and 0xFFFF go past the 21-bit range, so any saturation or sign handling on overflow shows up as a wrong total. A reset in mid-window must clear the published result and restart the 64-cycle count, which a design with a stale counter would violate.

// File: rtl/sm_accum_pkg.sv
package sm_accum_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_SUM_W    = 21;
    localparam int DEF_WINDOW   = 64;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_LAST = 1'b1
    } win_state_e;

endpackage

// File: rtl/sm_to_twos.sv
module sm_to_twos #(
    parameter int SAMPLE_W = 16,
    parameter int SUM_W    = 21
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SUM_W-1:0]    addend_o,
    output logic                cin_o
);
    localparam int MAG_W = SAMPLE_W - 1;
    localparam int EXT_W = SUM_W - MAG_W;

    logic             sign_w;
    logic [MAG_W-1:0] mag_w;

    always_comb begin
        sign_w   = sample_i[SAMPLE_W-1];
        mag_w    = sample_i[MAG_W-1:0] ^ {MAG_W{sign_w}};
        addend_o = {{EXT_W{sign_w}}, mag_w};
        cin_o    = sign_w;
    end

endmodule

// File: rtl/window_sequencer.sv
module window_sequencer
    import sm_accum_pkg::*;
#(
    parameter int WINDOW = 64
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic close_o
);
    localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] POS_PRELAST = CNT_W'(WINDOW - 2);
    localparam logic [CNT_W-1:0] POS_LAST    = CNT_W'(WINDOW - 1);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] pos_q, pos_d;

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_FILL: begin
                pos_d = pos_q + 1'b1;
                if (pos_q == POS_PRELAST) begin
                    state_d = ST_LAST;
                end
            end
            ST_LAST: begin
                pos_d   = '0;
                state_d = ST_FILL;
            end
            default: begin
                pos_d   = '0;
                state_d = ST_FILL;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_FILL;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FILL: close_o = 1'b0;
            ST_LAST: close_o = (pos_q == POS_LAST);
            default: close_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/accum_datapath.sv
module accum_datapath #(
    parameter int SUM_W = 21
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SUM_W-1:0] addend_i,
    input  logic             cin_i,
    input  logic             close_i,
    output logic [SUM_W-1:0] acc_o,
    output logic [SUM_W-1:0] sum_o,
    output logic             valid_o
);
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] next_w;
    logic [SUM_W-1:0] sum_q;
    logic             valid_q;

    assign next_w = acc_q + addend_i + {{(SUM_W-1){1'b0}}, cin_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q   <= '0;
            sum_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= close_i;
            if (close_i) begin
                sum_q <= next_w;
                acc_q <= '0;
            end else begin
                acc_q <= next_w;
            end
        end
    end

    assign acc_o   = acc_q;
    assign sum_o   = sum_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/sm_window_accum.sv
module sm_window_accum
    import sm_accum_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int SUM_W    = DEF_SUM_W,
    parameter int WINDOW   = DEF_WINDOW
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SUM_W-1:0]    sum_o,
    output logic                sum_valid_o
);
    logic [SUM_W-1:0] addend_w;
    logic             cin_w;
    logic             close_w;
    logic [SUM_W-1:0] acc_w;

    sm_to_twos #(
        .SAMPLE_W (SAMPLE_W),
        .SUM_W    (SUM_W)
    ) u_conv (
        .sample_i (sample_i),
        .addend_o (addend_w),
        .cin_o    (cin_w)
    );

    window_sequencer #(
        .WINDOW (WINDOW)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .close_o (close_w)
    );

    accum_datapath #(
        .SUM_W (SUM_W)
    ) u_dp (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .addend_i (addend_w),
        .cin_i    (cin_w),
        .close_i  (close_w),
        .acc_o    (acc_w),
        .sum_o    (sum_o),
        .valid_o  (sum_valid_o)
    );

endmodule

// File: rtl/sm_window_accum_chk.sv
module sm_window_accum_chk #(
    parameter int SAMPLE_W = 16,
    parameter int SUM_W    = 21,
    parameter int WINDOW   = 64
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic [SAMPLE_W-1:0] sample_i,
    input logic [SUM_W-1:0]    acc_i,
    input logic                close_i,
    input logic [SUM_W-1:0]    sum_i,
    input logic                valid_i
);
    localparam int CW = $clog2(WINDOW) + 1;
    localparam logic [SAMPLE_W-1:0] NEG_ZERO = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [CW-1:0] cyc_q;
    logic          wrapped_q;
    logic          armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cyc_q     <= '0;
            wrapped_q <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (cyc_q == CW'(WINDOW - 1)) begin
                cyc_q     <= '0;
                wrapped_q <= 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    p_negzero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (sample_i == NEG_ZERO && !close_i) |=> (acc_i == $past(acc_i)));

    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && !valid_i) |-> (sum_i == $past(sum_i)));

    p_period_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i == (wrapped_q && cyc_q == '0));

    p_single_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> !valid_i);

    p_fresh_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        close_i |=> (acc_i == '0));

    p_reset_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (sum_i == '0 && !valid_i));

endmodule

bind sm_window_accum sm_window_accum_chk #(
    .SAMPLE_W (SAMPLE_W),
    .SUM_W    (SUM_W),
    .WINDOW   (WINDOW)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .sample_i (sample_i),
    .acc_i    (acc_w),
    .close_i  (close_w),
    .sum_i    (sum_o),
    .valid_i  (sum_valid_o)
);

// File: tb/sm_window_accum_tb.sv
`timescale 1ns/1ps
module sm_window_accum_tb;

    localparam int WIN = 64;

    // {sample, expected 21-bit window total when all 64 samples equal it}
    localparam logic [36:0] VEC_TAB [8] = '{
        {16'h0001, 21'h000040},
        {16'h8001, 21'h1FFFC0},
        {16'h7FFF, 21'h1FFFC0},
        {16'hFFFF, 21'h000040},
        {16'h8000, 21'h000000},
        {16'h0000, 21'h000000},
        {16'h1234, 21'h048D00},
        {16'h9234, 21'h1B7300}
    };

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [15:0] sample_i = '0;
    logic [20:0] sum_o;
    logic        sum_valid_o;

    int checks = 0;
    int fails  = 0;
    int ref_sum = 0;
    int pos = 0;
    logic [20:0] pub = '0;
    bit done = 0;

    always #5 clk_i = ~clk_i;

    sm_window_accum u_dut (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sample_i    (sample_i),
        .sum_o       (sum_o),
        .sum_valid_o (sum_valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sm_value(input logic [15:0] s);
        int m;
        m = int'(s[14:0]);
        return s[15] ? -m : m;
    endfunction

    task automatic feed(input logic [15:0] s, input string req);
        sample_i = s;
        @(posedge clk_i);
        @(negedge clk_i);
        ref_sum += sm_value(s);
        pos++;
        if (pos == WIN) begin
            pos = 0;
            pub = ref_sum[20:0];
            ref_sum = 0;
            check(sum_valid_o == 1'b1, {req, " R5 pulse"}, int'(sum_valid_o), 1);
            check(sum_o == pub, {req, " R3 total"}, int'(sum_o), int'(pub));
        end else begin
            check(sum_valid_o == 1'b0, {req, " R5 no pulse"}, int'(sum_valid_o), 0);
            check(sum_o == pub, {req, " R4 hold"}, int'(sum_o), int'(pub));
        end
    endtask

    initial begin
        #100us;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk_i);
        check(sum_o == '0, "R8 reset sum", int'(sum_o), 0);
        check(sum_valid_o == 1'b0, "R8 reset pulse", int'(sum_valid_o), 0);
        rst_i = 1'b0;

        // R1 / R2 / R7: table of constant windows
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < WIN; k++) feed(VEC_TAB[i][36:21], "R1 table");
            check(pub == VEC_TAB[i][20:0], "R1/R2/R7 table total", int'(pub),
                  int'(VEC_TAB[i][20:0]));
        end

        // R9: 0, -1, +1, 0 cancel
        feed(16'h0000, "R9");
        feed(16'h8001, "R9");
        feed(16'h0001, "R9");
        feed(16'h0000, "R9");
        for (int k = 4; k < WIN; k++) feed(16'h0000, "R9");
        check(pub == '0, "R9 cancel total", int'(pub), 0);

        // R1: mixed signs against reference
        for (int k = 0; k < WIN; k++) begin
            if (k % 3 == 0) feed({1'b1, 15'(k * 517)}, "R1 mixed");
            else            feed({1'b0, 15'(k * 1031)}, "R1 mixed");
        end

        // R6: window edge, last sample of A and first sample of B
        for (int k = 0; k < WIN - 1; k++) feed(16'h0000, "R6");
        feed(16'h0007, "R6");
        check(pub == 21'd7, "R6 last sample kept", int'(pub), 7);
        feed(16'h0003, "R6");
        for (int k = 1; k < WIN; k++) feed(16'h0000, "R6");
        check(pub == 21'd3, "R6 first sample fresh", int'(pub), 3);

        // R8: reset mid-window
        for (int k = 0; k < 10; k++) feed(16'h0005, "R8 pre");
        rst_i = 1'b1;
        sample_i = 16'h7FFF;
        @(posedge clk_i);
        @(negedge clk_i);
        check(sum_o == '0, "R8 mid reset sum", int'(sum_o), 0);
        check(sum_valid_o == 1'b0, "R8 mid reset pulse", int'(sum_valid_o), 0);
        rst_i = 1'b0;
        ref_sum = 0;
        pos = 0;
        pub = '0;
        for (int k = 0; k < WIN; k++) feed(16'h0001, "R8 restart");
        check(pub == 21'd64, "R8 restart total", int'(pub), 64);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule